// File: doc/BRIEF.md
# USB Receive Byte Assembler

This block sits behind a clock/data recovery stage that hands it one line symbol (J, K or single-ended zero) per bit time, marked by a bit-valid strobe in the 60 MHz clock domain. It watches the idle line for the synchronisation pattern that opens a packet and strips that pattern. It then turns the symbol stream into decoded bits through NRZI decoding, drops the stuffed zero bits, and assembles the remaining bits into 8-bit bytes. The bytes appear on a UTMI-style receive interface.

Three framing outputs go to the consumer. `rxActive` is high from the detection of the start of a packet to its end. `rxValid` pulses for one cycle for each complete byte, and the consumer latches `rxData` on the rising clock edge of that cycle. `rxError` is a one-cycle pulse on the same timing as the data. A separate raw mode turns NRZI decoding and unstuffing off, so that a test pattern reaches the byte assembler untouched.

Top module: `usbRxDeser`

## Requirements
- R1: Symbols are 2-bit codes: 00 single-ended zero, 01 J, 10 K, 11 single-ended one. A symbol is taken only in a cycle where `symValid` is high. In every other cycle the value on `symbol` has no effect on any output.
- R2: In normal mode a decoded bit is 1 when the symbol equals the previous J/K symbol and 0 when it differs. The previous symbol is J after reset and again after every single-ended symbol.
- R3: Outside a packet, a run of at least five decoded 0 bits followed by a decoded 1 starts a packet. `rxActive` rises in the cycle after the closing 1 is taken. A run of four or fewer zeros starts nothing. Synchronisation bits never appear as data.
- R4: Data bits fill bytes least significant bit first. One cycle after the eighth data bit of a byte is taken, `rxValid` is high for exactly one cycle, with that byte on `rxData`.
- R5: In normal mode a 0 bit that directly follows six consecutive decoded 1 data bits is a stuff bit and is dropped. The run count restarts at the start of each packet.
- R6: In normal mode a 1 bit that directly follows six consecutive decoded 1 bits is a stuffing violation. It gives a one-cycle `rxError` pulse in the cycle after it is taken, only for the first violation of a packet. No further `rxValid` pulse occurs until the packet ends.
- R7: A single-ended symbol (00 or 11) taken during a packet ends it. `rxActive` falls in the next cycle.
- R8: If the packet ends with one to seven data bits of an unfinished byte, and no violation has occurred, `rxError` pulses in the same cycle that `rxActive` falls.
- R9: With `rawMode` high, a J symbol is bit 1 and a K symbol is bit 0, with no NRZI decoding. No bit is dropped as stuffing and no stuffing violation is raised. Packet start detection uses the same rule on these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Marks a cycle that carries one bit-time symbol |
| symbol | input | 2 | Line symbol code (see R1) |
| rawMode | input | 1 | 1 bypasses NRZI decoding and unstuffing |
| rxData | output | 8 | Received byte, valid while rxValid is high |
| rxValid | output | 1 | One-cycle pulse per completed byte |
| rxActive | output | 1 | High for the duration of a packet |
| rxError | output | 1 | One-cycle receive error pulse, data-aligned |

## Verification
The hardest condition to reach from the ports is a run of seven decoded ones inside a packet, because a correct transmitter never produces one. The bench drives a NRZI line-level model directly with its stuffing insertion switched off. It does this after a valid byte, so that the run that leads into the violation crosses a byte boundary. The violation is followed by two more bytes' worth of bits, which shows that valid pulses stay suppressed and that the unfinished byte at the end gives no second error. Throughout the run, idle cycles are scattered between symbols with a single-ended code left on the symbol lines, to show that non-strobed cycles are ignored.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } lineSym_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;   // take the current decoded bit as data
    logic clearBits;  // restart byte assembly
  } rxStrobe_t;

endpackage

// File: rtl/usbRxDatapath.sv
module usbRxDatapath
  import usbrx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [1:0]        symbol,
  input  logic              rawMode,
  input  rxStrobe_t         strobe,
  output logic              decBit,
  output logic              isEnd,
  output logic              lastBit,
  output logic              bitsEmpty,
  output logic [BYTE_W-1:0] rxData
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(BYTE_W - 1);

  logic [1:0]        prevSym;
  logic [BYTE_W-1:0] shiftReg;
  logic [CW-1:0]     bitCnt;
  logic [BYTE_W-1:0] nextShift;

  // single-ended codes have both bits equal
  assign isEnd     = (symbol[0] == symbol[1]);
  assign decBit    = rawMode ? (symbol == SYM_J) : (symbol == prevSym);
  assign lastBit   = (bitCnt == LAST_IDX);
  assign bitsEmpty = (bitCnt == '0);
  assign nextShift = {decBit, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSym <= SYM_J;
    end else if (symValid) begin
      prevSym <= isEnd ? SYM_J : symbol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxData   <= '0;
    end else if (strobe.clearBits) begin
      bitCnt <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= nextShift;
      if (lastBit) begin
        rxData <= nextShift;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/usbRxControl.sv
module usbRxControl
  import usbrx_pkg::*;
#(
  parameter int SYNC_ZEROS = 5,
  parameter int MAX_ONES   = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      symValid,
  input  logic      rawMode,
  input  logic      decBit,
  input  logic      isEnd,
  input  logic      lastBit,
  input  logic      bitsEmpty,
  output rxStrobe_t strobe,
  output logic      rxActive,
  output logic      rxValid,
  output logic      rxError
);

  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam int OW = $clog2(MAX_ONES + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_ZEROS);
  localparam logic [OW-1:0] OMAX = OW'(MAX_ONES);

  typedef enum logic {ST_IDLE, ST_BUSY} rxState_e;

  rxState_e      state;
  logic [ZW-1:0] zeroCnt;
  logic [OW-1:0] onesCnt;
  logic          errSticky;

  logic sopHit, endHit, busyBit, atLimit, violHit, stuffHit, dataHit;

  always_comb begin
    sopHit   = symValid && (state == ST_IDLE) && !isEnd && decBit && (zeroCnt == ZMAX);
    endHit   = symValid && (state == ST_BUSY) && isEnd;
    busyBit  = symValid && (state == ST_BUSY) && !isEnd;
    atLimit  = !rawMode && (onesCnt == OMAX);
    violHit  = busyBit && atLimit && decBit;
    stuffHit = busyBit && atLimit && !decBit;
    dataHit  = busyBit && !atLimit;
    strobe.shiftBit  = dataHit;
    strobe.clearBits = sopHit || endHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      zeroCnt   <= '0;
      onesCnt   <= '0;
      errSticky <= 1'b0;
      rxActive  <= 1'b0;
      rxValid   <= 1'b0;
      rxError   <= 1'b0;
    end else begin
      rxValid <= dataHit && lastBit && !errSticky;
      rxError <= !errSticky && (violHit || (endHit && !bitsEmpty));

      if (sopHit) begin
        state     <= ST_BUSY;
        rxActive  <= 1'b1;
        errSticky <= 1'b0;
      end else if (endHit) begin
        state    <= ST_IDLE;
        rxActive <= 1'b0;
      end

      if (state == ST_BUSY) begin
        zeroCnt <= '0;
      end else if (symValid) begin
        if (isEnd || decBit)   zeroCnt <= '0;
        else if (zeroCnt != ZMAX) zeroCnt <= zeroCnt + 1'b1;
      end

      if (sopHit || stuffHit) begin
        onesCnt <= '0;
      end else if (dataHit) begin
        onesCnt <= (!rawMode && decBit) ? onesCnt + 1'b1 : '0;
      end

      if (violHit) errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/usbRxDeser.sv
module usbRxDeser
  import usbrx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SYNC_ZEROS = 5,
  parameter int MAX_ONES   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [1:0]        symbol,
  input  logic              rawMode,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxActive,
  output logic              rxError
);

  rxStrobe_t strobe;
  logic decBit, isEnd, lastBit, bitsEmpty;

  usbRxDatapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symbol(symbol),
    .rawMode(rawMode), .strobe(strobe), .decBit(decBit), .isEnd(isEnd),
    .lastBit(lastBit), .bitsEmpty(bitsEmpty), .rxData(rxData)
  );

  usbRxControl #(.SYNC_ZEROS(SYNC_ZEROS), .MAX_ONES(MAX_ONES)) u_ctl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .rawMode(rawMode),
    .decBit(decBit), .isEnd(isEnd), .lastBit(lastBit), .bitsEmpty(bitsEmpty),
    .strobe(strobe), .rxActive(rxActive), .rxValid(rxValid), .rxError(rxError)
  );

endmodule

// File: rtl/usbRxDeser_chk.sv
module usbRxDeser_chk (
  input logic       clk,
  input logic       rstN,
  input logic       symValid,
  input logic [1:0] symbol,
  input logic       rxValid,
  input logic       rxActive,
  input logic       rxError
);

  AST_VALID_INSIDE_PKT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> rxActive); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R4
  AST_START_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxActive) |-> $past(symValid)); // R3
  AST_END_ON_SE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxActive) |-> $past(symValid && (symbol[0] == symbol[1]))); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxError |=> !rxError); // R6
  AST_ERR_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (rxError && !rxActive) |-> $past(rxActive)); // R8

endmodule

bind usbRxDeser usbRxDeser_chk u_chk (
  .clk(clk), .rstN(rstN), .symValid(symValid), .symbol(symbol),
  .rxValid(rxValid), .rxActive(rxActive), .rxError(rxError)
);

// File: tb/usbRxDeser_tb.sv
module usbRxDeser_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_SE0 = 2'b00, S_J = 2'b01, S_K = 2'b10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symbol = S_J;
  logic       rawMode = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, rxActive, rxError;

  int total = 0, bad = 0;
  int gapCtr = 0;
  int ones = 0;
  logic [1:0] lvl = S_J;
  logic [7:0] rcv [0:63];
  int rcvN = 0, errN = 0, riseN = 0;
  logic prevAct = 1'b0, errAtFall = 1'b0;
  logic [7:0] txb [0:15];
  int txN = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbRxDeser u_dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symbol(symbol),
    .rawMode(rawMode), .rxData(rxData), .rxValid(rxValid),
    .rxActive(rxActive), .rxError(rxError)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && rcvN < 64) begin rcv[rcvN] = rxData; rcvN++; end
      if (rxError) errN++;
      if (rxError && !rxActive && prevAct) errAtFall = 1'b1;
      if (rxActive && !prevAct) riseN++;
      prevAct = rxActive;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1: idle cycles with a single-ended code on the lines, strobe low
  task automatic sendSym(input logic [1:0] s);
    symbol = s; symValid = 1'b1;
    @(posedge clk); #1;
    symValid = 1'b0;
    gapCtr++;
    if (gapCtr % 3 == 0) begin
      symbol = S_SE0;
      @(posedge clk); #1;
    end
  endtask

  task automatic sendBit(input bit b);
    if (rawMode) sendSym(b ? S_J : S_K);
    else begin
      if (!b) lvl = (lvl == S_J) ? S_K : S_J;
      sendSym(lvl);
    end
  endtask

  task automatic sendDataBit(input bit b);
    sendBit(b);
    if (!rawMode) begin
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin sendBit(1'b0); ones = 0; end
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendDataBit(v[i]);
  endtask

  task automatic sendSync(input int zeros);
    lvl = S_J;
    for (int i = 0; i < zeros; i++) sendBit(1'b0);
    check(rxActive == 1'b0, "R3 inactive before closing sync bit", rxActive, 0);
    sendBit(1'b1);
    check(rxActive == 1'b1, "R3 active after sync", rxActive, 1);
    ones = 0;
  endtask

  task automatic sendEop();
    sendSym(S_SE0); sendSym(S_SE0); sendSym(S_J);
    lvl = S_J;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic clearMon();
    rcvN = 0; errN = 0; riseN = 0; errAtFall = 1'b0;
  endtask

  task automatic checkPacket(input string tag);
    int mism = 0;
    check(rcvN == txN, {tag, " byte count"}, rcvN, txN);
    for (int i = 0; i < txN && i < rcvN; i++)
      if (rcv[i] !== txb[i]) begin
        mism++;
        check(0, {tag, " byte value"}, rcv[i], txb[i]);
      end
    check(errN == 0, {tag, " no error"}, errN, 0);
    check(riseN == 1, {tag, " one active period"}, riseN, 1);
    check(rxActive == 1'b0, "R7 inactive after end", rxActive, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rxActive == 0 && rxValid == 0 && rxError == 0, "R7 reset outputs idle",
          {rxActive, rxValid, rxError}, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R2 R4 R5: every byte value, stuffing included
    for (int p = 0; p < 64; p++) begin
      clearMon();
      txN = 4;
      for (int i = 0; i < 4; i++) txb[i] = 8'(4 * p + i);
      sendSync(7);
      for (int i = 0; i < txN; i++) sendByte(txb[i]);
      sendEop();
      checkPacket("R4 R5 sweep");
    end

    // R5: long runs of ones forcing repeated stuff bits
    clearMon();
    txN = 4; txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'h7F; txb[3] = 8'hFE;
    sendSync(7);
    for (int i = 0; i < txN; i++) sendByte(txb[i]);
    sendEop();
    checkPacket("R5 ones runs");

    // R3: minimum sync of five zeros
    clearMon();
    txN = 1; txb[0] = 8'h81;
    sendSync(5);
    sendByte(txb[0]);
    sendEop();
    checkPacket("R3 five-zero sync");

    // R3: four zeros do not start a packet
    clearMon();
    lvl = S_J;
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    for (int i = 0; i < 12; i++) sendBit(1'b1);
    repeat (3) @(posedge clk);
    #1;
    check(riseN == 0, "R3 short sync ignored", riseN, 0);
    check(rcvN == 0, "R3 short sync no bytes", rcvN, 0);
    sendEop();

    // R6: violation after one good byte
    clearMon();
    sendSync(7);
    sendByte(8'hA5);
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    for (int i = 0; i < 16; i++) sendBit(i[0]);
    sendEop();
    check(rcvN == 1, "R6 only byte before violation", rcvN, 1);
    check(rcv[0] == 8'hA5, "R6 byte before violation", rcv[0], 8'hA5);
    check(errN == 1, "R6 single error pulse", errN, 1);
    check(errAtFall == 1'b0, "R8 no end error after violation", errAtFall, 0);

    // R8: trailing partial byte
    clearMon();
    sendSync(7);
    sendByte(8'h3C);
    sendDataBit(1'b1); sendDataBit(1'b0); sendDataBit(1'b1);
    sendEop();
    check(rcvN == 1 && rcv[0] == 8'h3C, "R8 full byte kept", rcv[0], 8'h3C);
    check(errN == 1, "R8 partial byte error", errN, 1);
    check(errAtFall == 1'b1, "R8 error with active fall", errAtFall, 1);

    // R9: raw mode, no unstuffing, no violation
    rawMode = 1'b1;
    clearMon();
    txN = 4; txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'h00; txb[3] = 8'h81;
    sendSync(7);
    for (int i = 0; i < txN; i++) sendByte(txb[i]);
    sendEop();
    checkPacket("R9 raw mode");
    rawMode = 1'b0;

    // R1: idle cycles alone change nothing
    clearMon();
    symbol = S_K;
    repeat (20) @(posedge clk);
    #1;
    check(riseN == 0 && rcvN == 0 && errN == 0, "R1 unstrobed symbols ignored",
          riseN + rcvN + errN, 0);
    symbol = S_J;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule